// File: doc/BRIEF.md
# Synchronous-Frame Phase Tracker

This block is the loop half of a single-phase grid synchroniser. A quadrature generator upstream supplies an in-phase and a quadrature sample pair once per sample strobe. The tracker turns that pair into a rotating d/q frame using its own phase estimate. It drives the d component to zero with a fixed-gain proportional-integral controller. It then adds a nominal-frequency feed-forward term to form the frequency estimate, and integrates that into a wrapped phase word. Unit-amplitude sine and cosine of the phase are read from an internal quarter-wave table. The cosine serves as the in-phase reference and the sine as the quadrature one.

Frequency is expressed as a phase increment per sample, in units where 2^32 is one full turn. With the default 20 kHz strobe, 50 Hz corresponds to 10737418. The proportional and integral gains are parameters in Q8. They are derived from a chosen loop bandwidth and a nominal input peak. The defaults correspond to a 55 Hz bandwidth at a peak of 16384 counts: KP = 369101 and KI = 6377. The integrator is clamped so that its contribution stays within 20 % of the nominal frequency.

Top module: `sfrm_tracker`

## Requirements
- R1: While `rst_n` is low at a clock edge the state is cleared: `phase_o` = 0, `freq_o` = 10737418, and `sin_o`/`cos_o` show the table entries for phase index 0.
- R2: While `smp_en` is low, `phase_o`, `freq_o`, `sin_o` and `cos_o` hold their values whatever `alpha_i` and `beta_i` do.
- R3: On each strobe `phase_o` advances by the `freq_o` value held before that strobe, modulo 2^32. With both inputs zero, `freq_o` stays at 10737418.
- R4: `sin_o` = round(32767·sin(2π(p+0.5)/1024)), where p = `phase_o[31:22]`. `cos_o` is the same function at (p+256) mod 1024.
- R5: On a strobe the error is e = −((alpha·sin_o − beta·cos_o) >>> 15), using `sin_o`/`cos_o` from before the strobe. The integrator gains e·KI, and `freq_o` becomes 10737418 + floor(integrator/256) + floor(e·KP/256).
- R6: The integrator is clamped to ±2147483·256. A sustained error of one sign therefore holds `freq_o` at 10737418 ± 2147483 plus the proportional term.
- R7: For an ideal pair alpha = A·cos φ and beta = A·sin φ with A = 16384, at 46 Hz and at a frequency in 47–54 Hz, `freq_o` converges. Its mean over the last 400 samples lies within 0.3 % of the input rate, each sample lies within 2 %, and `phase_o` stays within 3° of the next input phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_en | input | 1 | Sample strobe, one cycle per input pair |
| alpha_i | input | 16 | In-phase input sample, signed |
| beta_i | input | 16 | Quadrature input sample, signed |
| freq_o | output | 32 | Frequency estimate as signed phase increment per sample |
| phase_o | output | 32 | Wrapped phase estimate, 2^32 per turn |
| sin_o | output | 16 | Sine of the phase, signed Q1.15 |
| cos_o | output | 16 | Cosine of the phase, signed Q1.15 |

## Verification
On every cycle, the assertions check the reset state, state hold between strobes, and the integrator clamp. They also check that a zero error leaves the frequency equal to the feed-forward plus the integrator, and that the sine/cosine pair stays on the unit circle within rounding. Some behaviour is visible only through bench scenarios. These include the exact single-step arithmetic of the controller, the bit-exact table contents, and phase accumulation across many strobes and through wrap. Lock at off-nominal frequencies and the saturated frequency under a forced quarter-turn error are likewise shown only by the bench.

// File: rtl/sfrm_pkg.sv
package sfrm_pkg;
    // 50 Hz at a 20 kHz strobe, 2^32 increments per turn
    localparam longint DEF_NOM_INC = 64'd10737418;
    // Q8 gains for a 55 Hz loop bandwidth at a 16384-count nominal peak
    localparam int DEF_KP_Q = 369101;
    localparam int DEF_KI_Q = 6377;

    typedef enum logic [1:0] {
        QD_RISE     = 2'd0,
        QD_FALL     = 2'd1,
        QD_NEG_FALL = 2'd2,
        QD_NEG_RISE = 2'd3
    } quad_e;
endpackage

// File: rtl/sfrm_sincos.sv
module sfrm_sincos
    import sfrm_pkg::*;
#(
    parameter int OUT_W = 16,
    parameter int IDX_W = 8
) (
    input  logic [IDX_W+1:0]        ang_i,
    output logic signed [OUT_W-1:0] sin_o,
    output logic signed [OUT_W-1:0] cos_o
);
    localparam int  QN     = 1 << IDX_W;
    localparam int  AMP    = (1 << (OUT_W - 1)) - 1;
    localparam real TWO_PI = 6.283185307179586;

    logic signed [OUT_W-1:0] qtab [QN];

    // quarter wave sampled at half-step offsets so mirroring is exact
    for (genvar i = 0; i < QN; i++) begin : g_tab
        localparam real ARG = TWO_PI * (real'(i) + 0.5) / real'(4 * QN);
        localparam int  VAL = int'($sin(ARG) * real'(AMP));
        assign qtab[i] = OUT_W'(VAL);
    end

    logic [IDX_W+1:0]        ang [2];
    logic signed [OUT_W-1:0] val [2];

    // channel 0 is sine, channel 1 is sine a quarter turn ahead (cosine)
    for (genvar k = 0; k < 2; k++) begin : g_ch
        quad_e                   quad;
        logic [IDX_W-1:0]        idx;
        logic signed [OUT_W-1:0] mag;
        assign ang[k] = ang_i + (IDX_W + 2)'(k * QN);
        assign quad   = quad_e'(ang[k][IDX_W+1:IDX_W]);
        assign idx    = ang[k][IDX_W-1:0];
        assign mag    = (quad == QD_FALL || quad == QD_NEG_RISE) ? qtab[~idx] : qtab[idx];
        assign val[k] = (quad == QD_NEG_FALL || quad == QD_NEG_RISE) ? -mag : mag;
    end

    assign sin_o = val[0];
    assign cos_o = val[1];
endmodule

// File: rtl/sfrm_rotate.sv
module sfrm_rotate #(
    parameter int DATA_W = 16,
    parameter int ERR_W  = DATA_W + 2
) (
    input  logic signed [DATA_W-1:0] alpha_i,
    input  logic signed [DATA_W-1:0] beta_i,
    input  logic signed [DATA_W-1:0] sin_i,
    input  logic signed [DATA_W-1:0] cos_i,
    output logic signed [ERR_W-1:0]  err_o
);
    localparam int PROD_W = 2 * DATA_W;
    localparam int FRAC   = DATA_W - 1;

    logic signed [PROD_W-1:0] prod_a;
    logic signed [PROD_W-1:0] prod_b;
    logic signed [PROD_W:0]   diff;
    logic signed [ERR_W-1:0]  vd;

    assign prod_a = alpha_i * sin_i;
    assign prod_b = beta_i * cos_i;
    assign diff   = {prod_a[PROD_W-1], prod_a} - {prod_b[PROD_W-1], prod_b};
    assign vd     = ERR_W'(diff >>> FRAC);
    // reference for d is zero, so the error is the negated d component
    assign err_o  = -vd;
endmodule

// File: rtl/sfrm_pi.sv
module sfrm_pi #(
    parameter int     ERR_W  = 18,
    parameter int     ACC_W  = 48,
    parameter int     FREQ_W = 32,
    parameter int     KP_Q   = 369101,
    parameter int     KI_Q   = 6377,
    parameter int     SH     = 8,
    parameter longint LIM_Q  = 64'd549755648
) (
    input  logic signed [ERR_W-1:0]  err_i,
    input  logic signed [ACC_W-1:0]  integ_i,
    output logic signed [ACC_W-1:0]  integ_o,
    output logic signed [FREQ_W-1:0] ctrl_o
);
    localparam logic signed [ACC_W-1:0] KP_S  = ACC_W'(KP_Q);
    localparam logic signed [ACC_W-1:0] KI_S  = ACC_W'(KI_Q);
    localparam logic signed [ACC_W-1:0] LIM_S = ACC_W'(LIM_Q);

    logic signed [ACC_W-1:0] err_x;
    logic signed [ACC_W-1:0] p_term;
    logic signed [ACC_W-1:0] i_sum;

    assign err_x  = {{(ACC_W - ERR_W){err_i[ERR_W-1]}}, err_i};
    assign p_term = (err_x * KP_S) >>> SH;
    assign i_sum  = integ_i + err_x * KI_S;

    always_comb begin
        if (i_sum > LIM_S) begin
            integ_o = LIM_S;
        end else if (i_sum < -LIM_S) begin
            integ_o = -LIM_S;
        end else begin
            integ_o = i_sum;
        end
    end

    assign ctrl_o = FREQ_W'((integ_o >>> SH) + p_term);
endmodule

// File: rtl/sfrm_tracker.sv
module sfrm_tracker
    import sfrm_pkg::*;
#(
    parameter int     DATA_W    = 16,
    parameter int     PH_W      = 32,
    parameter int     FREQ_W    = 32,
    parameter int     LUT_IDX_W = 8,
    parameter int     GAIN_SH   = 8,
    parameter longint NOM_INC   = DEF_NOM_INC,
    parameter int     KP_Q      = DEF_KP_Q,
    parameter int     KI_Q      = DEF_KI_Q,
    parameter int     LIM_PCT   = 20
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_en,
    input  logic signed [DATA_W-1:0] alpha_i,
    input  logic signed [DATA_W-1:0] beta_i,
    output logic signed [FREQ_W-1:0] freq_o,
    output logic [PH_W-1:0]          phase_o,
    output logic signed [DATA_W-1:0] sin_o,
    output logic signed [DATA_W-1:0] cos_o
);
    localparam int     ERR_W   = DATA_W + 2;
    localparam int     ACC_W   = FREQ_W + GAIN_SH + 8;
    localparam int     ANG_W   = LUT_IDX_W + 2;
    localparam longint LIM_INC = NOM_INC * LIM_PCT / 100;
    localparam longint LIM_Q   = LIM_INC << GAIN_SH;
    localparam longint AMP     = (64'd1 << (DATA_W - 1)) - 1;

    typedef struct packed {
        logic [PH_W-1:0]   phase;
        logic [FREQ_W-1:0] freq;
        logic [ACC_W-1:0]  integ;
    } trk_t;

    trk_t st_d, st_q;

    logic signed [ERR_W-1:0]  err;
    logic signed [ACC_W-1:0]  integ_nx;
    logic signed [FREQ_W-1:0] ctrl;

    sfrm_sincos #(
        .OUT_W (DATA_W),
        .IDX_W (LUT_IDX_W)
    ) u_lut (
        .ang_i (st_q.phase[PH_W-1 -: ANG_W]),
        .sin_o (sin_o),
        .cos_o (cos_o)
    );

    sfrm_rotate #(
        .DATA_W (DATA_W),
        .ERR_W  (ERR_W)
    ) u_rot (
        .alpha_i (alpha_i),
        .beta_i  (beta_i),
        .sin_i   (sin_o),
        .cos_i   (cos_o),
        .err_o   (err)
    );

    sfrm_pi #(
        .ERR_W  (ERR_W),
        .ACC_W  (ACC_W),
        .FREQ_W (FREQ_W),
        .KP_Q   (KP_Q),
        .KI_Q   (KI_Q),
        .SH     (GAIN_SH),
        .LIM_Q  (LIM_Q)
    ) u_pi (
        .err_i   (err),
        .integ_i (st_q.integ),
        .integ_o (integ_nx),
        .ctrl_o  (ctrl)
    );

    always_comb begin
        st_d = st_q;
        if (smp_en) begin
            st_d.integ = integ_nx;
            st_d.freq  = FREQ_W'(NOM_INC) + ctrl;
            st_d.phase = st_q.phase + PH_W'(st_q.freq);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{phase: '0, freq: FREQ_W'(NOM_INC), integ: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign freq_o  = st_q.freq;
    assign phase_o = st_q.phase;

    // R1: reset clears phase and loads the feed-forward frequency
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (phase_o == '0 && freq_o == FREQ_W'(NOM_INC)));

    // R2: no strobe, no state change
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_en |=> $stable(st_q));

    // R5: zero error leaves frequency at feed-forward plus integrator
    p_ffwd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_en && err == '0) |=>
        (freq_o == FREQ_W'(NOM_INC + (longint'($signed(st_q.integ)) >>> GAIN_SH))));

    // R6: integrator never leaves its clamp window
    p_int_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (longint'($signed(st_q.integ)) <= LIM_Q && longint'($signed(st_q.integ)) >= -LIM_Q));

    // R4: sine and cosine stay on the unit circle within rounding
    p_unit_circle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((longint'(sin_o) * longint'(sin_o) + longint'(cos_o) * longint'(cos_o) <= AMP * AMP + 2 * AMP)
         && (longint'(sin_o) * longint'(sin_o) + longint'(cos_o) * longint'(cos_o) >= AMP * AMP - 2 * AMP)));
endmodule

// File: tb/sfrm_tracker_test.sv
module sfrm_tracker_test;
    // expected constants from the requirements
    localparam longint NOM  = 64'd10737418;
    localparam longint KP   = 64'd369101;
    localparam longint KI   = 64'd6377;
    localparam longint LIM  = 64'd2147483;
    localparam real    TWOPI = 6.283185307179586;
    localparam real    TS    = 50.0e-6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_en = 1'b0;
    logic signed [15:0] alpha = '0;
    logic signed [15:0] beta = '0;
    logic signed [31:0] freq;
    logic [31:0]        phase;
    logic signed [15:0] sin_v;
    logic signed [15:0] cos_v;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sfrm_tracker uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp_en  (smp_en),
        .alpha_i (alpha),
        .beta_i  (beta),
        .freq_o  (freq),
        .phase_o (phase),
        .sin_o   (sin_v),
        .cos_o   (cos_v)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint rnd(input real x);
        return (x >= 0.0) ? longint'($rtoi(x + 0.5)) : -longint'($rtoi(-x + 0.5));
    endfunction

    function automatic longint tab(input int i);
        return rnd(32767.0 * $sin(TWOPI * (real'(i % 1024) + 0.5) / 1024.0));
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; smp_en = 1'b0; alpha = '0; beta = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic strobe(input longint a, input longint b);
        alpha = 16'(a); beta = 16'(b); smp_en = 1'b1;
        @(negedge clk);
        smp_en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic chk_lut(input string tag);
        int p;
        p = int'(phase[31:22]);
        chk(longint'(sin_v) == tab(p), {"R4 sine ", tag}, longint'(sin_v), tab(p));
        chk(longint'(cos_v) == tab(p + 256), {"R4 cosine ", tag}, longint'(cos_v), tab(p + 256));
    endtask

    task automatic chk_reset_state();
        chk(phase == 32'd0, "R1 phase", longint'(phase), 0);
        chk(longint'(freq) == NOM, "R1 freq", longint'(freq), NOM);
        chk(longint'(sin_v) == tab(0), "R1 sine", longint'(sin_v), tab(0));
        chk(longint'(cos_v) == tab(256), "R1 cosine", longint'(cos_v), tab(256));
    endtask

    // R5: one strobe from reset, then one zero-input strobe
    task automatic step_case(input longint a, input longint b);
        longint vd, e, integ, f1, f2;
        do_reset();
        vd = (a * tab(0) - b * tab(256)) >>> 15;
        e = -vd;
        integ = e * KI;
        f1 = NOM + (integ >>> 8) + ((e * KP) >>> 8);
        f2 = NOM + (integ >>> 8);
        strobe(a, b);
        chk(longint'(freq) == f1, "R5 first-step freq", longint'(freq), f1);
        chk(longint'(phase) == NOM, "R3 first-step phase", longint'(phase), NOM);
        strobe(0, 0);
        chk(longint'(freq) == f2, "R5 integrator retained", longint'(freq), f2);
    endtask

    task automatic track(input real fhz, input int n, input string tag);
        real    ph, expf;
        longint sum, pw, a, b;
        int     cnt, d;
        ph = real'($urandom % 1000) / 1000.0;
        expf = fhz * TS * 4294967296.0;
        sum = 0; cnt = 0;
        for (int k = 0; k < n; k++) begin
            a = rnd(16384.0 * $cos(TWOPI * ph));
            b = rnd(16384.0 * $sin(TWOPI * ph));
            strobe(a, b);
            ph = ph + fhz * TS;
            if (ph >= 1.0) ph = ph - 1.0;
            if (k >= n - 400) begin
                sum += longint'(freq);
                cnt++;
                if (k % 20 == 0) begin
                    pw = longint'(ph * 4294967296.0);
                    d = int'(phase - 32'(pw));
                    chk((d < 35791394) && (d > -35791394), {"R7 phase error ", tag},
                        longint'(d), 0);
                    chk((real'(freq) - expf < 0.02 * expf) && (expf - real'(freq) < 0.02 * expf),
                        {"R7 freq sample ", tag}, longint'(freq), longint'(expf));
                end
                if (k % 50 == 0) chk_lut(tag);
            end
        end
        chk((real'(sum) / real'(cnt) - expf < 0.003 * expf) &&
            (expf - real'(sum) / real'(cnt) < 0.003 * expf),
            {"R7 mean freq ", tag}, sum / longint'(cnt), longint'(expf));
    endtask

    // R6: bench keeps the input a quarter turn off the estimate
    task automatic sat_run(input longint amp, input int dir, input string tag);
        real    th, ph;
        longint a, b, expf, act;
        expf = NOM + longint'(dir) * (LIM + amp * KP / 256);
        for (int k = 0; k < 300; k++) begin
            th = real'(phase) / 4294967296.0;
            ph = th + real'(dir) * 0.25;
            a = rnd(real'(amp) * $cos(TWOPI * ph));
            b = rnd(real'(amp) * $sin(TWOPI * ph));
            strobe(a, b);
            if (k >= 200 && k % 10 == 0) begin
                act = longint'(freq);
                chk((act - expf < 6000) && (expf - act < 6000), {"R6 clamped freq ", tag}, act, expf);
            end
        end
    endtask

    initial begin
        longint hf, hp;
        void'($urandom(32'd20240517));
        do_reset();
        chk_reset_state();

        // R2: inputs wiggle but no strobe
        alpha = 16'sd12000; beta = -16'sd9000;
        repeat (10) @(negedge clk);
        chk(longint'(freq) == NOM, "R2 freq hold at reset state", longint'(freq), NOM);
        chk(phase == 32'd0, "R2 phase hold at reset state", longint'(phase), 0);

        // R5 directed corners then random pairs
        step_case(-32768, 32767);
        step_case(32767, -32768);
        step_case(0, 0);
        step_case(16384, 0);
        for (int i = 0; i < 16; i++) begin
            step_case(longint'($signed(16'($urandom))), longint'($signed(16'($urandom))));
        end

        // R2: after nonzero state, hold without strobe
        hf = longint'(freq); hp = longint'(phase);
        for (int i = 0; i < 20; i++) begin
            alpha = 16'($urandom); beta = 16'($urandom);
            @(negedge clk);
        end
        chk(longint'(freq) == hf, "R2 freq hold", longint'(freq), hf);
        chk(longint'(phase) == hp, "R2 phase hold", longint'(phase), hp);
        chk_lut("after hold");

        // R3: zero input, pure feed-forward accumulation through wrap
        do_reset();
        for (int n = 1; n <= 500; n++) begin
            strobe(0, 0);
            if (n == 1 || n == 100 || n == 401 || n == 500) begin
                chk(longint'(phase) == ((longint'(n) * NOM) & 64'hFFFF_FFFF), "R3 phase accumulation",
                    longint'(phase), (longint'(n) * NOM) & 64'hFFFF_FFFF);
                chk(longint'(freq) == NOM, "R3 freq steady", longint'(freq), NOM);
                chk_lut("accumulate");
            end
        end

        // R7: lock at 46 Hz and at a random frequency in range
        do_reset();
        track(46.0, 3000, "46Hz");
        do_reset();
        track(47.0 + real'($urandom % 700) / 100.0, 3000, "random");

        // R6: positive and negative clamp
        do_reset();
        sat_run(2000, 1, "positive");
        do_reset();
        sat_run(2000, -1, "negative");

        // R1: reset from a saturated state
        do_reset();
        chk_reset_state();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule